// File: doc/BRIEF.md
# Masked Serial Sync Word Correlator

This block watches a serial NRZ bit stream, one bit per clock cycle in which the bit enable is high. It keeps the most recent bits in a sliding window and compares them against a programmable sync word of 1 to 64 bits. A per-bit mask removes chosen positions from the comparison. Positions at or above the programmed length are also removed. Two mismatch counts are formed in parallel: one against the sync word and one against its bitwise inverse.

Each count is compared with a programmed error allowance of 0 to 15 bits. A hit on the true word is reported on `hit_true` and a hit on the inverted word on `hit_inv`. When both would qualify, only `hit_true` is raised. The raw counts are also brought out so that a downstream frame synchronizer can grade its decisions.

All configuration inputs are static levels that software holds steady. The asynchronous active-low reset is expected to be released synchronously to `clk` by the surrounding logic.

Top module: `sync_correlator`

## Requirements
- R1: While `rst_n` is low, and after reset until the first result is loaded, `hit_true` and `hit_inv` are 0 and both counts are 0.
- R2: A bit is taken into the window only in a cycle with `bit_en` high. The newest bit enters window position 0, and older bits move one position up. In cycles with `bit_en` low, the value of `bit_in` has no effect on any output.
- R3: `err_true` equals the number of window positions i for which position i is active and window[i] differs from `sync_word[i]`.
- R4: `err_inv` equals the number of active positions i for which window[i] equals `sync_word[i]`, that is, the mismatch count against the inverted word.
- R5: Position i is active only when `sync_mask[i]` is 1 and i < `sync_len`. Inactive positions never add to either count.
- R6: `hit_true` is 1 exactly when `err_true` ≤ `err_allow` (0 to 15) and the fill condition of R8 holds.
- R7: `hit_inv` is 1 exactly when `err_inv` ≤ `err_allow`, the fill condition holds, and `hit_true` is not 1. The two hit outputs are never 1 together.
- R8: Neither hit can be 1 until at least `sync_len` bits (1 to 64) have been accepted since the last reset.
- R9: The window register updates at the clock edge that accepts a bit. The hits and counts for that window appear one clock edge later, and until then they still show the earlier window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_en | input | 1 | Accept `bit_in` into the window this cycle |
| bit_in | input | 1 | Serial NRZ data bit |
| sync_len | input | 7 | Sync word length in bits, 1 to 64 |
| sync_word | input | 64 | Sync word; bit 0 is compared with the newest bit |
| sync_mask | input | 64 | 1 = position takes part in the comparison |
| err_allow | input | 4 | Largest mismatch count still accepted as a hit |
| hit_true | output | 1 | Window matches the sync word within the allowance |
| hit_inv | output | 1 | Window matches the inverted word within the allowance (true hit not present) |
| err_true | output | 7 | Mismatch count against the sync word |
| err_inv | output | 7 | Mismatch count against the inverted sync word |

## Verification
The hardest condition to reach is the case where both the true and the inverted word qualify at once. The two counts always add up to the number of active positions, so this case requires a short word with a large allowance. The stimulus uses an 8-bit word with an allowance of 4 and a window that differs in exactly four positions, which exercises the priority rule. A second awkward case is a window of reset zeros against an all-zero sync word, which compares equal before any bit has arrived. A test checks each bit step after reset to show that the fill gate alone holds the hits low until the eighth bit.

// File: rtl/sync_corr_pkg.sv
package sync_corr_pkg;
  // widest supported sync word
  localparam int unsigned WIN_MAX = 64;
  // width of the error allowance field (0..15)
  localparam int unsigned TOL_W   = 4;
endpackage

// File: rtl/sync_window.sv
module sync_window #(
  parameter int unsigned WIN_W = 64,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [WIN_W-1:0] win_q,
  output logic [CNT_W-1:0] fill_q
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WIN_W);

  logic [WIN_W-1:0] win_d;
  logic [CNT_W-1:0] fill_d;

  always_comb begin
    win_d  = win_q;
    fill_d = fill_q;
    if (bit_en) begin
      win_d = {win_q[WIN_W-2:0], bit_in};
      if (fill_q != FULL) fill_d = fill_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_en) begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> win_q[0] == $past(bit_in));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(win_q) && $stable(fill_q));
  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL);
endmodule

// File: rtl/sync_popcnt.sv
module sync_popcnt #(
  parameter int unsigned WIN_W  = 64,
  parameter int unsigned CNT_W  = 7,
  parameter bit          INVERT = 1'b0
) (
  input  logic [WIN_W-1:0] win,
  input  logic [WIN_W-1:0] word,
  input  logic [WIN_W-1:0] act_mask,
  output logic [CNT_W-1:0] cnt
);
  logic [WIN_W-1:0] ref_word;
  logic [WIN_W-1:0] diff;

  generate
    if (INVERT) begin : g_inv
      assign ref_word = ~word;
    end else begin : g_true
      assign ref_word = word;
    end
  endgenerate

  assign diff = (win ^ ref_word) & act_mask;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < WIN_W; i++) begin
      cnt = cnt + CNT_W'(diff[i]);
    end
  end
endmodule

// File: rtl/sync_correlator.sv
module sync_correlator #(
  parameter int unsigned WIN_W = sync_corr_pkg::WIN_MAX,
  parameter int unsigned TOL_W = sync_corr_pkg::TOL_W,
  parameter int unsigned CNT_W = $clog2(WIN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] sync_len,
  input  logic [WIN_W-1:0] sync_word,
  input  logic [WIN_W-1:0] sync_mask,
  input  logic [TOL_W-1:0] err_allow,
  output logic             hit_true,
  output logic             hit_inv,
  output logic [CNT_W-1:0] err_true,
  output logic [CNT_W-1:0] err_inv
);
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] fill_q;
  logic [WIN_W-1:0] act_mask;
  logic [CNT_W-1:0] cnt_t, cnt_i;
  logic [CNT_W-1:0] allow_w;
  logic             ready;
  logic             hit_t_d, hit_i_d;
  logic             res_vld;

  sync_window #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .bit_in (bit_in),
    .win_q  (win_q),
    .fill_q (fill_q)
  );

  // positions at or above the programmed length are masked off
  for (genvar i = 0; i < WIN_W; i++) begin : g_act
    assign act_mask[i] = sync_mask[i] & (CNT_W'(i) < sync_len);
  end

  sync_popcnt #(.WIN_W(WIN_W), .CNT_W(CNT_W), .INVERT(1'b0)) u_cnt_true (
    .win      (win_q),
    .word     (sync_word),
    .act_mask (act_mask),
    .cnt      (cnt_t)
  );

  sync_popcnt #(.WIN_W(WIN_W), .CNT_W(CNT_W), .INVERT(1'b1)) u_cnt_inv (
    .win      (win_q),
    .word     (sync_word),
    .act_mask (act_mask),
    .cnt      (cnt_i)
  );

  assign allow_w = CNT_W'(err_allow);
  assign ready   = fill_q >= sync_len;

  always_comb begin
    hit_t_d = ready && (cnt_t <= allow_w);
    hit_i_d = ready && (cnt_i <= allow_w) && !hit_t_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_true <= 1'b0;
      hit_inv  <= 1'b0;
      err_true <= '0;
      err_inv  <= '0;
      res_vld  <= 1'b0;
    end else begin
      hit_true <= hit_t_d;
      hit_inv  <= hit_i_d;
      err_true <= cnt_t;
      err_inv  <= cnt_i;
      res_vld  <= 1'b1;
    end
  end

  // R7
  excl_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_true && hit_inv));
  // R3 R4 R5
  count_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> ({1'b0, err_true} + {1'b0, err_inv}) ==
                (CNT_W+1)'($countones($past(act_mask))));
  // R8
  fill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_true || hit_inv) |-> $past(fill_q) >= $past(sync_len));
  // R6
  allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_true |-> err_true <= CNT_W'($past(err_allow)));
endmodule

// File: tb/test_sync_correlator.sv
module test_sync_correlator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en;
  logic        bit_in;
  logic [6:0]  sync_len;
  logic [63:0] sync_word;
  logic [63:0] sync_mask;
  logic [3:0]  err_allow;
  logic        hit_true, hit_inv;
  logic [6:0]  err_true, err_inv;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [63:0] bw;
  int          nb;

  always #4 clk = ~clk;

  sync_correlator i_sync_correlator (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .sync_len(sync_len), .sync_word(sync_word), .sync_mask(sync_mask),
    .err_allow(err_allow), .hit_true(hit_true), .hit_inv(hit_inv),
    .err_true(err_true), .err_inv(err_inv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_errs(input logic [63:0] w, input logic [63:0] p,
                                  input logic [63:0] m, input int len, input bit inv);
    int c = 0;
    for (int i = 0; i < 64; i++)
      if (i < len && m[i] && (w[i] != (p[i] ^ inv))) c++;
    return c;
  endfunction

  task automatic check_outs(input string req);
    int  e   = exp_errs(bw, sync_word, sync_mask, int'(sync_len), 1'b0);
    int  ce  = exp_errs(bw, sync_word, sync_mask, int'(sync_len), 1'b1);
    bit  rdy = nb >= int'(sync_len);
    bit  eh  = rdy && e <= int'(err_allow);
    bit  ech = rdy && ce <= int'(err_allow) && !eh;
    chk(int'(err_true) == e,  {req, " err_true"}, int'(err_true), e);
    chk(int'(err_inv)  == ce, {req, " err_inv"},  int'(err_inv),  ce);
    chk(hit_true == eh,       {req, " hit_true"}, int'(hit_true), int'(eh));
    chk(hit_inv  == ech,      {req, " hit_inv"},  int'(hit_inv),  int'(ech));
  endtask

  task automatic step(input logic b);
    @(negedge clk); bit_en = 1'b1; bit_in = b;
    @(negedge clk); bit_en = 1'b0;
    bw = {bw[62:0], b};
    if (nb < 64) nb++;
    @(negedge clk);
  endtask

  task automatic feed(input logic [63:0] w, input int n, input string req);
    for (int i = n - 1; i >= 0; i--) begin
      step(w[i]);
      check_outs(req);
    end
  endtask

  task automatic set_cfg(input int len, input logic [63:0] p, input logic [63:0] m, input int tol);
    @(negedge clk);
    sync_len = 7'(len); sync_word = p; sync_mask = m; err_allow = 4'(tol);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0;
    @(negedge clk);
    // R1
    chk(!hit_true && !hit_inv, "R1 hits in reset", int'({hit_true, hit_inv}), 0);
    chk(err_true == 0 && err_inv == 0, "R1 counts in reset", int'(err_true) + int'(err_inv), 0);
    @(negedge clk); rst_n = 1'b1; bw = '0; nb = 0;
    @(negedge clk);
  endtask

  task automatic t_fill;
    t_reset();
    set_cfg(8, 64'h0, {64{1'b1}}, 0);
    // R8: zero window equals zero word yet nothing accepted
    check_outs("R8 before bits");
    chk(!hit_true, "R8 no hit at empty", int'(hit_true), 0);
    feed(64'h0, 7, "R8 partial fill");
    step(1'b0);
    check_outs("R8 full");
    chk(hit_true, "R8 hit after len bits", int'(hit_true), 1);
  endtask

  task automatic t_exact;
    t_reset();
    set_cfg(16, 64'h0000_0000_0000_B5C3, {64{1'b1}}, 0);
    feed(64'hB5C3 >> 1, 15, "R3 exact lead-in");
    // R9: last bit by hand to observe the extra stage
    @(negedge clk); bit_en = 1'b1; bit_in = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    chk(!hit_true, "R9 hit not before result edge", int'(hit_true), 0);
    bw = {bw[62:0], 1'b1}; nb++;
    @(negedge clk);
    check_outs("R9 after result edge");
    chk(hit_true && err_true == 0 && err_inv == 16, "R3 exact match",
        int'(err_inv), 16);
  endtask

  task automatic t_inverse;
    feed(~64'h0000_0000_0000_B5C3, 16, "R4 inverted word");
    chk(hit_inv && !hit_true, "R4 inverted hit", int'({hit_true, hit_inv}), 1);
  endtask

  task automatic t_allow;
    set_cfg(32, 64'h0000_0000_9E37_79B9, {64{1'b1}}, 2);
    feed(64'h9E37_79B9 ^ 64'h0001_0240, 32, "R6 three errors allow 2");
    chk(!hit_true && err_true == 3, "R6 over allowance", int'(err_true), 3);
    set_cfg(32, 64'h0000_0000_9E37_79B9, {64{1'b1}}, 3);
    check_outs("R6 allow 3");
    chk(hit_true, "R6 at allowance", int'(hit_true), 1);
  endtask

  task automatic t_mask;
    set_cfg(16, 64'h0000_0000_0000_A50F, 64'h0000_0000_0000_FF00, 0);
    feed(64'hA5F0, 16, "R5 masked low byte");
    chk(hit_true && err_true == 0 && err_inv == 8, "R5 mask ignores", int'(err_inv), 8);
    // upper positions hold earlier bits; length cuts them out
    set_cfg(4, 64'h0000_0000_0000_0000, {64{1'b1}}, 0);
    check_outs("R5 length limit");
    chk(err_true + err_inv == 4, "R5 only len positions", int'(err_true) + int'(err_inv), 4);
  endtask

  task automatic t_priority;
    set_cfg(8, 64'h0000_0000_0000_00F0, {64{1'b1}}, 4);
    feed(64'hFF, 8, "R7 both qualify");
    chk(hit_true && !hit_inv && err_true == 4 && err_inv == 4, "R7 true wins",
        int'({hit_true, hit_inv}), 2);
  endtask

  task automatic t_enable;
    set_cfg(1, 64'h1, {64{1'b1}}, 0);
    step(1'b1);
    check_outs("R2 newest at LSB");
    chk(hit_true, "R2 lsb match", int'(hit_true), 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); bit_en = 1'b0; bit_in = k[0];
    end
    @(negedge clk);
    check_outs("R2 disabled bits ignored");
    chk(hit_true && !hit_inv, "R2 hold", int'(hit_true), 1);
    step(1'b0);
    check_outs("R2 new zero");
    chk(hit_inv, "R2 zero gives inverted hit", int'(hit_inv), 1);
  endtask

  task automatic t_wide;
    set_cfg(64, 64'hC3A5_5A3C_0F1E_7896, {64{1'b1}}, 15);
    feed(64'hC3A5_5A3C_0F1E_7896 ^ 64'h0000_0000_0000_7FFF, 64, "R6 fifteen errors");
    chk(hit_true && err_true == 15, "R6 max allowance", int'(err_true), 15);
    feed(64'hC3A5_5A3C_0F1E_7896 ^ 64'h8000_0000_0000_7FFF, 64, "R6 sixteen errors");
    chk(!hit_true && err_true == 16, "R6 beyond max", int'(err_true), 16);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0;
    sync_len = 7'd8; sync_word = '0; sync_mask = '1; err_allow = '0;
    bw = '0; nb = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_exact();
    t_inverse();
    t_allow();
    t_mask();
    t_priority();
    t_enable();
    t_wide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule